// File: doc/BRIEF.md
# DRAM Command Payload Sequencer

The sequencer replays a short program of DRAM commands held in an external instruction memory. After a start pulse it waits for a grant from the bus handover logic. The grant arrives once the memory controller has released the bus, which happens after its next refresh. The sequencer then walks the memory from entry 0 and places each activate, read, precharge or refresh on phase 0 of a multi-phase command bus. Every instruction holds its slot for a programmed number of cycles, called its timeslice.

Two further instruction kinds control the program. A NOOP only spends time. A LOOP steps back a programmed number of entries a programmed number of times, using one shared loop counter. A NOOP with a zero timeslice is the stop instruction, and an all-zero word decodes as that stop. Execution also ends after the last memory entry has run. The instruction memory has a synchronous read port with one cycle of latency. The sequencer steers its address so that the next word is ready in the cycle after the current instruction ends, which leaves no fetch bubbles between instructions.

Top module: `payload_seq`

## Requirements
- R1: After reset, and whenever the block is idle, ready_o=1, executing_o=0, and every bit of cs_n_o, ras_n_o, cas_n_o and we_n_o is 1.
- R2: A start pulse seen while idle drops ready_o in the next cycle. executing_o stays 0 until grant_i is sampled high, and it rises in the cycle after that sample.
- R3: Instruction word layout from the LSB: opcode[2:0], timeslice[TS_W], bank[BANK_W], address[ADDR_W]. The opcodes are 0 NOOP, 1 ACT, 2 READ, 3 PRE, 4 REF and 5 LOOP. A command pulls cs_n_o[0] low in the first cycle of its timeslice, with {ras_n,cas_n,we_n} set to ACT 011, READ 101, PRE 010 or REF 001. cmd_bank_o and cmd_addr_o carry the bank and address fields. All other phases stay at 1.
- R4: Each command or NOOP instruction occupies max(1, timeslice) cycles of executing_o. Phase 0 is deasserted in every cycle after the first.
- R5: A NOOP with timeslice 0 is a stop: it takes exactly 1 cycle and ends execution. An all-zero word is such a stop.
- R6: A NOOP places no command on the bus. Only ACT, READ, PRE and REF are issued, in program order.
- R7: A LOOP takes 1 cycle. Its fields from the LSB are opcode[2:0], count[LOOP_W] and jump[PC_W]. With count N-1, the range from entry pc-jump up to the LOOP runs N times in total. The single loop counter returns to zero when the loop exits.
- R8: Without a stop, execution ends after the instruction at entry DEPTH-1. A memory filled with timeslice-1 NOOPs runs for exactly DEPTH cycles.
- R9: ready_o rises in the cycle after the last executing cycle. ready_o and executing_o are never both 1.
- R10: A start pulse that arrives while the block is waiting or executing is ignored. The run length does not change, and the block stays idle afterwards.
- R11: A command encoded with timeslice 0 is still issued and takes exactly 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to run the program |
| grant_i | input | 1 | Bus handed over to the sequencer |
| ready_o | output | 1 | Idle, accepting a start |
| executing_o | output | 1 | Program running |
| imem_addr_o | output | PC_W | Instruction memory read address |
| imem_data_i | input | INSTR_W | Instruction word, one cycle after its address |
| cs_n_o | output | PHASES | Per-phase chip select, active low |
| ras_n_o | output | PHASES | Per-phase row strobe, active low |
| cas_n_o | output | PHASES | Per-phase column strobe, active low |
| we_n_o | output | PHASES | Per-phase write enable, active low |
| cmd_bank_o | output | BANK_W | Bank of the phase 0 command |
| cmd_addr_o | output | ADDR_W | Row or column of the phase 0 command |

## Verification
The bench builds the sequencer with an 8-entry memory, 4-bit timeslices, 4-bit loop counts, 3 bank bits, 8 row bits, 6 column bits and two phases. At this size a whole program fits in eight words. The end-of-memory exit, loops that jump back to entry 0 and the full timeslice range can all be reached in a few hundred cycles. A small interpreter in the bench derives the expected command stream and cycle count for each program. Directed programs run alongside many pseudo-random programs that mix zero timeslices, stops and one loop, under varied grant delays and stray start pulses.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_NOOP = 3'd0;
  localparam logic [OP_W-1:0] OP_ACT  = 3'd1;
  localparam logic [OP_W-1:0] OP_READ = 3'd2;
  localparam logic [OP_W-1:0] OP_PRE  = 3'd3;
  localparam logic [OP_W-1:0] OP_REF  = 3'd4;
  localparam logic [OP_W-1:0] OP_LOOP = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EXEC} seq_state_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int TS_W   = 6,
  parameter int BANK_W = 5,
  parameter int ADDR_W = 18,
  parameter int LOOP_W = 8,
  parameter int PC_W   = 5,
  localparam int INSTR_W = OP_W + TS_W + BANK_W + ADDR_W
) (
  input  logic [INSTR_W-1:0] word_i,
  output logic [OP_W-1:0]    op_o,
  output logic [TS_W-1:0]    ts_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [LOOP_W-1:0]  lcount_o,
  output logic [PC_W-1:0]    ljump_o
);
  assign op_o     = word_i[OP_W-1:0];
  assign ts_o     = word_i[OP_W +: TS_W];
  assign bank_o   = word_i[OP_W+TS_W +: BANK_W];
  assign addr_o   = word_i[OP_W+TS_W+BANK_W +: ADDR_W];
  // loop fields overlay the command fields
  assign lcount_o = word_i[OP_W +: LOOP_W];
  assign ljump_o  = word_i[OP_W+LOOP_W +: PC_W];
endmodule

// File: rtl/seq_loop_ctl.sv
module seq_loop_ctl #(
  parameter int LOOP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [LOOP_W-1:0] count_i,
  output logic              take_o
);
  logic [LOOP_W-1:0] iter_q;

  assign take_o = (iter_q != count_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      iter_q <= '0;
    else if (clear_i) iter_q <= '0;
    else if (step_i)  iter_q <= take_o ? iter_q + LOOP_W'(1) : '0;
  end
endmodule

// File: rtl/seq_cmd_drive.sv
module seq_cmd_drive
  import seq_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int BANK_W = 5,
  parameter int ADDR_W = 18
) (
  input  logic              issue_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PHASES-1:0] cs_n_o,
  output logic [PHASES-1:0] ras_n_o,
  output logic [PHASES-1:0] cas_n_o,
  output logic [PHASES-1:0] we_n_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic       cmd_vld;
  logic [2:0] rcw_n;  // {ras_n, cas_n, we_n}

  always_comb begin
    cmd_vld = issue_i;
    rcw_n   = 3'b111;
    unique case (op_i)
      OP_ACT:  rcw_n = 3'b011;
      OP_READ: rcw_n = 3'b101;
      OP_PRE:  rcw_n = 3'b010;
      OP_REF:  rcw_n = 3'b001;
      default: cmd_vld = 1'b0;
    endcase
    if (!cmd_vld) rcw_n = 3'b111;
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    if (p == 0) begin : g_cmd
      assign cs_n_o[p]  = ~cmd_vld;
      assign ras_n_o[p] = rcw_n[2];
      assign cas_n_o[p] = rcw_n[1];
      assign we_n_o[p]  = rcw_n[0];
    end else begin : g_idle
      assign cs_n_o[p]  = 1'b1;
      assign ras_n_o[p] = 1'b1;
      assign cas_n_o[p] = 1'b1;
      assign we_n_o[p]  = 1'b1;
    end
  end

  assign bank_o = cmd_vld ? bank_i : '0;
  assign addr_o = cmd_vld ? addr_i : '0;
endmodule

// File: rtl/payload_seq.sv
module payload_seq
  import seq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int TS_W   = 6,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 10,
  parameter int LOOP_W = 8,
  parameter int PHASES = 4,
  localparam int PC_W    = $clog2(DEPTH),
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int INSTR_W = OP_W + TS_W + BANK_W + ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               grant_i,
  output logic               ready_o,
  output logic               executing_o,
  output logic [PC_W-1:0]    imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  output logic [PHASES-1:0]  cs_n_o,
  output logic [PHASES-1:0]  ras_n_o,
  output logic [PHASES-1:0]  cas_n_o,
  output logic [PHASES-1:0]  we_n_o,
  output logic [BANK_W-1:0]  cmd_bank_o,
  output logic [ADDR_W-1:0]  cmd_addr_o
);
  seq_state_e state_q;
  logic [PC_W-1:0] pc_q, next_pc;
  logic [TS_W-1:0] cnt_q;

  logic [OP_W-1:0]   op;
  logic [TS_W-1:0]   ts;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] addr;
  logic [LOOP_W-1:0] lcount;
  logic [PC_W-1:0]   ljump;

  logic exec, is_loop, is_stop, slot_last, take_jump, jumping, at_end, finish;

  seq_decode #(
    .TS_W(TS_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LOOP_W(LOOP_W), .PC_W(PC_W)
  ) u_dec (
    .word_i(imem_data_i), .op_o(op), .ts_o(ts), .bank_o(bank), .addr_o(addr),
    .lcount_o(lcount), .ljump_o(ljump)
  );

  assign exec      = (state_q == ST_EXEC);
  assign is_loop   = (op == OP_LOOP);
  assign is_stop   = (op == OP_NOOP) && (ts == '0);
  // loop and stop always last one cycle; ts 0 counts as 1
  assign slot_last = is_loop || (ts == '0) || (cnt_q == ts - TS_W'(1));
  assign jumping   = is_loop && take_jump;
  assign at_end    = (pc_q == PC_W'(DEPTH - 1));
  assign finish    = exec && slot_last && (is_stop || (!jumping && at_end));
  assign next_pc   = jumping ? pc_q - ljump : pc_q + PC_W'(1);

  // present the next word during the last cycle so it arrives without a bubble
  assign imem_addr_o = (exec && slot_last) ? next_pc : pc_q;

  seq_loop_ctl #(.LOOP_W(LOOP_W)) u_loop (
    .clk_i, .rst_ni,
    .clear_i(!exec),
    .step_i (exec && is_loop),
    .count_i(lcount),
    .take_o (take_jump)
  );

  seq_cmd_drive #(.PHASES(PHASES), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_drv (
    .issue_i(exec && (cnt_q == '0)),
    .op_i(op), .bank_i(bank), .addr_i(addr),
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o,
    .bank_o(cmd_bank_o), .addr_o(cmd_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          pc_q    <= '0;
        end
        ST_WAIT: if (grant_i) begin
          state_q <= ST_EXEC;
          cnt_q   <= '0;
        end
        ST_EXEC: begin
          if (slot_last) begin
            cnt_q <= '0;
            if (finish) state_q <= ST_IDLE;
            else        pc_q    <= next_pc;
          end else begin
            cnt_q <= cnt_q + TS_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign executing_o = exec;
endmodule

// File: rtl/payload_seq_chk.sv
module payload_seq_chk #(
  parameter int PHASES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              grant_i,
  input logic              ready_o,
  input logic              executing_o,
  input logic [PHASES-1:0] cs_n_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&cs_n_o)); // R1
  AST_GRANT_BEFORE_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(executing_o) |-> $past(grant_i)); // R2
  AST_UPPER_PHASES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o | PHASES'(1)) == {PHASES{1'b1}}); // R3
  AST_CMD_ONLY_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o[0] |-> executing_o); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && executing_o)); // R9
  AST_LEAVE_IDLE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(start_i)); // R10
endmodule

bind payload_seq payload_seq_chk #(.PHASES(PHASES)) u_chk (
  .clk_i, .rst_ni, .start_i, .grant_i, .ready_o, .executing_o, .cs_n_o
);

// File: tb/payload_seq_tb.sv
module payload_seq_tb;
  localparam int DEPTH = 8, TS_W = 4, BANK_W = 3, ROW_W = 8, COL_W = 6;
  localparam int LOOP_W = 4, PHASES = 2;
  localparam int PC_W = 3, ADDR_W = 8, INSTR_W = 3 + TS_W + BANK_W + ADDR_W;
  localparam int MAXC = 1024;

  logic clk = 0, rst_ni = 0, start = 0, grant = 0;
  logic ready, executing;
  logic [PC_W-1:0] imem_addr;
  logic [INSTR_W-1:0] rdata;
  logic [PHASES-1:0] cs_n, ras_n, cas_n, we_n;
  logic [BANK_W-1:0] cbank;
  logic [ADDR_W-1:0] caddr;
  logic [INSTR_W-1:0] mem [DEPTH];

  always #5 clk = ~clk;
  always_ff @(posedge clk) rdata <= mem[imem_addr];

  payload_seq #(.DEPTH(DEPTH), .TS_W(TS_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
                .COL_W(COL_W), .LOOP_W(LOOP_W), .PHASES(PHASES)) u_dut (
    .clk_i(clk), .rst_ni, .start_i(start), .grant_i(grant), .ready_o(ready),
    .executing_o(executing), .imem_addr_o(imem_addr), .imem_data_i(rdata),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .cmd_bank_o(cbank), .cmd_addr_o(caddr));

  int errors = 0, checks = 0;
  int exp_n, exp_cyc;
  int exp_op [MAXC];
  int exp_bank [MAXC];
  int exp_addr [MAXC];
  logic [31:0] lfsr = 32'h1d2c3b4a;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [INSTR_W-1:0] enc_cmd(int op, int ts, int bank, int addr);
    return {addr[ADDR_W-1:0], bank[BANK_W-1:0], ts[TS_W-1:0], op[2:0]};
  endfunction

  function automatic logic [INSTR_W-1:0] enc_loop(int cnt, int jmp);
    logic [INSTR_W-1:0] w = '0;
    w[2:0] = 3'd5;
    w[3 +: LOOP_W] = cnt[LOOP_W-1:0];
    w[3+LOOP_W +: PC_W] = jmp[PC_W-1:0];
    return w;
  endfunction

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]);
  endfunction

  // expected stream and cycle count from the instruction semantics
  task automatic model();
    int pc = 0, lc = 0, guard = 0;
    exp_n = 0; exp_cyc = 0;
    while (guard < 4000) begin
      logic [INSTR_W-1:0] w = mem[pc];
      int op = int'(w[2:0]);
      int ts = int'(w[3 +: TS_W]);
      guard++;
      if (op == 0 && ts == 0) begin exp_cyc++; break; end
      if (op == 5) begin
        int cnt = int'(w[3 +: LOOP_W]);
        int jmp = int'(w[3+LOOP_W +: PC_W]);
        exp_cyc++;
        if (lc != cnt) begin lc++; pc = (pc - jmp) & (DEPTH - 1); continue; end
        lc = 0;
      end else begin
        exp_cyc += (ts == 0) ? 1 : ts;
        if (op >= 1 && op <= 4 && exp_n < MAXC) begin
          exp_op[exp_n] = op;
          exp_bank[exp_n] = int'(w[3+TS_W +: BANK_W]);
          exp_addr[exp_n] = int'(w[3+TS_W+BANK_W +: ADDR_W]);
          exp_n++;
        end
      end
      if (pc == DEPTH - 1) break;
      pc++;
    end
  endtask

  function automatic int pin_op(logic r, logic c, logic w);
    case ({r, c, w})
      3'b011: return 1;
      3'b101: return 2;
      3'b010: return 3;
      3'b001: return 4;
      default: return 7;
    endcase
  endfunction

  task automatic run(string tag, int gdelay, bit poke);
    int cyc = 0, got = 0, bad = 0;
    model();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(!ready && !executing, {tag, " R2 leave idle"}, int'(ready), 0);
    for (int i = 0; i < gdelay; i++) begin
      @(negedge clk);
      if (poke && i == 0) start = 1; else start = 0;
      if (executing) bad++;
    end
    check(bad == 0, {tag, " R2 wait for grant"}, bad, 0);
    start = 0; grant = 1;
    @(negedge clk); grant = 0;
    check(executing == 1, {tag, " R2 start after grant"}, int'(executing), 1);
    bad = 0;
    while (executing && cyc < 5000) begin
      cyc++;
      start = (poke && cyc == 2);
      if (cs_n[1] !== 1'b1) bad++;
      if (cs_n[0] === 1'b0) begin
        if (got >= exp_n || pin_op(ras_n[0], cas_n[0], we_n[0]) != exp_op[got] ||
            int'(cbank) != exp_bank[got] || int'(caddr) != exp_addr[got]) bad++;
        got++;
      end
      @(negedge clk);
    end
    start = 0;
    check(bad == 0 && got == exp_n, {tag, " R3 R6 R7 command stream"}, got, exp_n);
    check(cyc == exp_cyc, {tag, " R4 R5 R8 R11 executing cycles"}, cyc, exp_cyc);
    check(ready && !executing, {tag, " R9 ready after run"}, int'(ready), 1);
    repeat (3) @(negedge clk);
    check(ready && cs_n == '1, {tag, " R10 stays idle"}, int'(ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check(ready && !executing && cs_n == '1 && ras_n == '1 && cas_n == '1 && we_n == '1,
          "R1 reset state", int'(ready), 1);

    // directed: plain sequence with stop
    mem[0] = enc_cmd(1, 3, 1, 100); mem[1] = enc_cmd(2, 2, 1, 13);
    mem[2] = enc_cmd(3, 1, 1, 0);   mem[3] = enc_cmd(4, 4, 0, 0);
    mem[4] = '0;                    mem[5] = enc_cmd(1, 5, 2, 7);
    run("seq", 2, 0);
    check(exp_cyc == 11 && exp_n == 4, "R5 model sanity", exp_cyc, 11);

    // directed: two counted loops
    mem[0] = enc_cmd(1, 2, 0, 100); mem[1] = enc_cmd(2, 1, 0, 5);
    mem[2] = enc_loop(3, 1);        mem[3] = enc_cmd(3, 1, 0, 0);
    mem[4] = enc_cmd(4, 2, 0, 0);   mem[5] = enc_cmd(4, 1, 0, 0);
    mem[6] = enc_loop(1, 2);        mem[7] = '0;
    run("loop", 1, 1);
    check(exp_n == 1 + 4 + 1 + 4, "R7 loop count", exp_n, 10);

    // directed: NOOP fill, runs to the end of memory
    for (int i = 0; i < DEPTH; i++) mem[i] = enc_cmd(0, 1, 0, 0);
    run("noopfill", 1, 0);
    check(exp_cyc == DEPTH, "R8 depth cycles", exp_cyc, DEPTH);

    // directed: empty memory is a stop
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    run("zero", 3, 0);

    // directed: zero-timeslice command
    mem[0] = enc_cmd(1, 0, 5, 200); mem[1] = '0;
    run("ts0", 1, 0);

    // sweep of generated programs with at most one loop
    for (int t = 0; t < 80; t++) begin
      bit have_loop = 0;
      for (int i = 0; i < DEPTH; i++) begin
        int r = rnd();
        int k = r % 8;
        if (k == 5 && !have_loop && i > 0) begin
          mem[i] = enc_loop((r >> 4) % 4, (r >> 8) % (i + 1));
          have_loop = 1;
        end else if (k == 0) mem[i] = enc_cmd(0, (r >> 3) % 16, 0, 0);
        else if (k >= 1 && k <= 4) mem[i] = enc_cmd(k, (r >> 3) % 16, rnd(), rnd());
        else mem[i] = enc_cmd(1, 1 + (r >> 3) % 15, rnd(), rnd());
      end
      run("sweep", 1 + t % 4, t[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule